// File: doc/BRIEF.md
# Free-Running Bus Timer with Coherent Byte Reads

This block is a 16-bit up-counter that runs from the bus clock through a fixed divide-by-four prescaler. It sits behind an 8-bit register port. Software reaches the count through two windows, and each window is a pair of bytes. Because the count is wider than the bus, reading the high byte of either window captures the low byte of the same instant into a holding buffer. The next low-byte read then returns that captured byte. Software therefore always sees a consistent 16-bit value, even though the two halves arrive in separate bus cycles.

When the count wraps from all ones to zero, a sticky overflow flag is set. An interrupt request follows when the overflow interrupt enable is set. The flag is cleared by a two-step handshake:
- First, software reads the status byte while the flag is set. This arms the clear.
- Then a high-byte read of the primary window clears the flag.

The alternate window returns the same count as the primary window but never takes part in clearing the flag. Background code can therefore sample time without disturbing the overflow handshake. A 16-bit compare-value register is also provided. It is plain read/write storage, and neither reset nor the counter ever alters it.

The register map is as follows. The count only advances while the run bit is set.

| Offset | Contents |
|---|---|
| 0x12 | Control: bit 0 is the run enable, bit 1 is the overflow interrupt enable |
| 0x13 | Status: bit 7 is the overflow flag; the other bits read 0 |
| 0x16 / 0x17 | Compare value, high byte / low byte |
| 0x18 / 0x19 | Primary count window, high byte / low byte |
| 0x1A / 0x1B | Alternate count window, high byte / low byte |

Unmapped offsets read 0. The read data is combinational and is valid while the read strobe is high. Read side effects take place at the clock edge that ends the read cycle.

Two small state machines carry the behaviour:
- **Capture machine**
  - States: HOLD_LIVE and HOLD_FROZEN.
  - HOLD_LIVE → HOLD_FROZEN on a high-byte read of either window. The live low byte is captured on this transition.
  - HOLD_FROZEN → HOLD_LIVE on a low-byte read of either window.
  - Every other input keeps the current state.
- **Clear-arming machine**
  - States: ARM_IDLE and ARM_READY.
  - ARM_IDLE → ARM_READY on a status read while the flag is set.
  - ARM_READY → ARM_IDLE on a primary high-byte read.
  - Every other input keeps the current state.

Top module: `frc_timer`

## Requirements
- R1: After reset the count reads 0xFFFC, and the control byte, status byte and interrupt output read 0.
- R2: While the run bit (control bit 0) is 0, the count does not change, and the prescaler is held at its start.
- R3: While running, the count increments by one every four clocks. The first increment lands on the fourth clock edge after the edge that writes the run bit to 1.
- R4: The count wrapping from 0xFFFF to 0x0000 sets the overflow flag, which reads as status bit 7.
- R5: The interrupt output equals the overflow flag ANDed with the interrupt enable (control bit 1), registered one clock later.
- R6: A high-byte read of either window (0x18 or 0x1A) in HOLD_LIVE captures the live low byte. Further high-byte reads leave the capture unchanged, and the next low-byte read (0x19 or 0x1B) returns the captured byte.
- R7: A low-byte read with no capture pending returns the live low byte. A low-byte read releases a pending capture.
- R8: A primary high-byte read (0x18) clears the flag only when a status read (0x13) saw the flag set earlier. A high-byte read with no such arming leaves the flag set.
- R9: Reads of the alternate window (0x1A, 0x1B) never change the overflow flag.
- R10: The compare value (0x16 high byte, 0x17 low byte) reads back what was last written, and reset leaves it unchanged.
- R11: Writes to the count windows leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register offset |
| rd | input | 1 | Read strobe; side effects at the closing clock edge |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd is high; 0 otherwise |
| irq | output | 1 | Registered overflow interrupt request |

## Verification
The assertions take for granted that read and write are never high together and that they stay stable from one clock edge to the next. They also assume the counter wraps at most once within a stretch checked by the flag properties. The stimulus drives the strobes one at a time on falling edges. From reset, it keeps each run short enough that only one wrap ever occurs. A behavioural model in the bench tracks the count, the capture buffer, the arming state and the interrupt on every clock. It compares the model against the read data and the interrupt output, and it adds fixed expected values at the reset, enable and wrap points.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic {
        HOLD_LIVE,
        HOLD_FROZEN
    } hold_state_e;

    typedef enum logic {
        ARM_IDLE,
        ARM_READY
    } arm_state_e;

endpackage

// File: rtl/frc_prescale.sv
module frc_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && (phase_q == LAST);

    generate
        if (DIV > 1) begin : g_gap
            // R3: ticks are never back to back
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/frc_count.sv
module frc_count #(
    parameter int W = 16,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= RESET_VAL;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
    assign wrap  = tick && (count_q == '1);

    // R3: the count only ever holds or steps by one
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/frc_hold.sv
module frc_hold
    import frc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_read,
    input  logic          lo_read,
    input  logic [DW-1:0] live_lo,
    output logic [DW-1:0] lo_view
);
    hold_state_e   state_q, state_d;
    logic [DW-1:0] buf_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_LIVE:   if (hi_read) state_d = HOLD_FROZEN;
            HOLD_FROZEN: if (lo_read) state_d = HOLD_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (state_q == HOLD_LIVE && hi_read) begin
            buf_q <= live_lo;
        end
    end

    always_comb begin
        unique case (state_q)
            HOLD_LIVE:   lo_view = live_lo;
            HOLD_FROZEN: lo_view = buf_q;
        endcase
    end

    // R6: a frozen capture survives repeated high-byte reads
    a_r6_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HOLD_FROZEN && !lo_read) |=> (state_q == HOLD_FROZEN) && $stable(buf_q));

    // R7: a low-byte read always leaves the machine live
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_read && !hi_read) |=> state_q == HOLD_LIVE);

endmodule

// File: rtl/frc_ovf.sv
module frc_ovf
    import frc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic status_read,
    input  logic clear_read,
    input  logic ie,
    output logic flag,
    output logic irq
);
    arm_state_e arm_q, arm_d;
    logic       flag_q;
    logic       irq_q;

    always_comb begin
        arm_d = arm_q;
        unique case (arm_q)
            ARM_IDLE:  if (status_read && flag_q) arm_d = ARM_READY;
            ARM_READY: if (clear_read)            arm_d = ARM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= ARM_IDLE;
        end else begin
            arm_q <= arm_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= flag_q && ie;
            if (wrap) begin
                flag_q <= 1'b1;
            end else if (clear_read && arm_q == ARM_READY) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag = flag_q;
    assign irq  = irq_q;

    // R5: a rising request needs flag and enable one clock earlier
    a_r5_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(flag_q && ie));

    // R4: a wrap always leaves the flag set
    a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);

endmodule

// File: rtl/frc_timer.sv
module frc_timer #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int PRESCALE = 4,
    parameter logic [2*DW-1:0] RESET_COUNT = 'hFFFC,
    parameter logic [AW-1:0] CTRL_ADDR   = 'h12,
    parameter logic [AW-1:0] STAT_ADDR   = 'h13,
    parameter logic [AW-1:0] CMP_HI_ADDR = 'h16,
    parameter logic [AW-1:0] CMP_LO_ADDR = 'h17,
    parameter logic [AW-1:0] CNT_HI_ADDR = 'h18,
    parameter logic [AW-1:0] CNT_LO_ADDR = 'h19,
    parameter logic [AW-1:0] ALT_HI_ADDR = 'h1A,
    parameter logic [AW-1:0] ALT_LO_ADDR = 'h1B,
    parameter int RUN_BIT  = 0,
    parameter int IE_BIT   = 1,
    parameter int FLAG_BIT = DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    localparam int CW = 2 * DW;

    logic          run_q, ie_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] count;
    logic          tick, wrap, flag;
    logic [DW-1:0] lo_view;

    logic rd_cnt_hi, rd_alt_hi, rd_any_lo, rd_stat;

    assign rd_cnt_hi = rd && (addr == CNT_HI_ADDR);
    assign rd_alt_hi = rd && (addr == ALT_HI_ADDR);
    assign rd_any_lo = rd && ((addr == CNT_LO_ADDR) || (addr == ALT_LO_ADDR));
    assign rd_stat   = rd && (addr == STAT_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
        end else if (wr && addr == CTRL_ADDR) begin
            run_q <= wdata[RUN_BIT];
            ie_q  <= wdata[IE_BIT];
        end
    end

    // compare value: storage only, untouched by reset
    always_ff @(posedge clk) begin
        if (wr && addr == CMP_HI_ADDR) cmp_q[CW-1:DW] <= wdata;
        if (wr && addr == CMP_LO_ADDR) cmp_q[DW-1:0]  <= wdata;
    end

    frc_prescale #(.DIV(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .tick  (tick)
    );

    frc_count #(.W(CW), .RESET_VAL(RESET_COUNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (count),
        .wrap  (wrap)
    );

    frc_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_read (rd_cnt_hi || rd_alt_hi),
        .lo_read (rd_any_lo),
        .live_lo (count[DW-1:0]),
        .lo_view (lo_view)
    );

    frc_ovf u_ovf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap        (wrap),
        .status_read (rd_stat),
        .clear_read  (rd_cnt_hi),
        .ie          (ie_q),
        .flag        (flag),
        .irq         (irq)
    );

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                CTRL_ADDR: begin
                    rdata[RUN_BIT] = run_q;
                    rdata[IE_BIT]  = ie_q;
                end
                STAT_ADDR:   rdata[FLAG_BIT] = flag;
                CMP_HI_ADDR: rdata = cmp_q[CW-1:DW];
                CMP_LO_ADDR: rdata = cmp_q[DW-1:0];
                CNT_HI_ADDR: rdata = count[CW-1:DW];
                ALT_HI_ADDR: rdata = count[CW-1:DW];
                CNT_LO_ADDR: rdata = lo_view;
                ALT_LO_ADDR: rdata = lo_view;
                default:     rdata = '0;
            endcase
        end
    end

    // R2: a stopped timer keeps its count
    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable(count));

    // R4: the flag is set whenever the count has just wrapped
    a_r4_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(count) == '1) && (count == '0)) |-> flag);

    // R8: the flag only falls after a primary high-byte read
    a_r8_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(rd && addr == CNT_HI_ADDR));

    // R9: alternate-window reads never drop the flag
    a_r9_alt_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (addr == ALT_HI_ADDR || addr == ALT_LO_ADDR)) |=> !$fell(flag));

endmodule

// File: tb/sim_frc_timer.sv
module sim_frc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_cnt = 'hFFFC, m_pre = 0, m_buf = 0, m_cmp = 0;
    bit m_run = 0, m_ie = 0, m_flag = 0, m_arm = 0, m_held = 0, m_irq = 0;

    always #5 clk = ~clk;

    frc_timer u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 'hFFFC; m_pre = 0; m_run = 0; m_ie = 0; m_flag = 0;
            m_arm = 0; m_held = 0; m_irq = 0;
        end else begin
            bit nirq, tk, clr, wrp;
            nirq = m_flag && m_ie;
            tk   = m_run && (m_pre == 3);
            clr  = rd && addr == 8'h18 && m_arm;
            wrp  = 0;
            if (rd && addr == 8'h13 && m_flag) m_arm = 1;
            if (clr) m_arm = 0;
            if (rd && (addr == 8'h18 || addr == 8'h1A) && !m_held) begin
                m_buf = m_cnt % 256; m_held = 1;
            end else if (rd && (addr == 8'h19 || addr == 8'h1B)) begin
                m_held = 0;
            end
            m_pre = m_run ? (m_pre + 1) % 4 : 0;
            if (tk) begin
                if (m_cnt == 'hFFFF) begin m_cnt = 0; wrp = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (wrp) m_flag = 1; else if (clr) m_flag = 0;
            if (wr && addr == 8'h12) begin m_run = wdata[0]; m_ie = wdata[1]; end
            if (wr && addr == 8'h16) m_cmp = (m_cmp % 256) + wdata * 256;
            if (wr && addr == 8'h17) m_cmp = (m_cmp / 256) * 256 + wdata;
            m_irq = nirq;
        end
    end

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        case (a)
            8'h12: return {6'b0, m_ie, m_run};
            8'h13: return {m_flag, 7'b0};
            8'h16: return 8'(m_cmp / 256);
            8'h17: return 8'(m_cmp % 256);
            8'h18, 8'h1A: return 8'(m_cnt / 256);
            8'h19, 8'h1B: return m_held ? 8'(m_buf) : 8'(m_cnt % 256);
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // one bus cycle, entered just after a falling edge
    task automatic op(input logic [7:0] a, input bit r, input bit w,
                      input logic [7:0] d, input string tag, output logic [7:0] got);
        addr = a; rd = r; wr = w; wdata = d;
        #1;
        got = rdata;
        if (r) chk(tag, rdata, model_rd(a));
        @(posedge clk);
        @(negedge clk);
        rd = 0; wr = 0;
        chk({tag, " irq"}, {7'b0, irq}, {7'b0, m_irq});
    endtask

    task automatic idle(input int n, input string tag);
        logic [7:0] g;
        for (int i = 0; i < n; i++) op(8'h00, 0, 0, 8'h00, tag, g);
    endtask

    task automatic rdx(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] g;
        op(a, 1, 0, 8'h00, tag, g);
        chk({tag, " literal"}, g, exp);
    endtask

    task automatic rdm(input logic [7:0] a, input string tag);
        logic [7:0] g;
        op(a, 1, 0, 8'h00, tag, g);
    endtask

    task automatic wrt(input logic [7:0] a, input logic [7:0] d, input string tag);
        logic [7:0] g;
        op(a, 0, 1, d, tag, g);
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle(2, "reset");
        rst_n = 1;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1
        rdx(8'h12, 8'h00, "R1 ctrl");
        rdx(8'h13, 8'h00, "R1 status");
        rdx(8'h18, 8'hFF, "R1 count hi");
        rdx(8'h19, 8'hFC, "R1 count lo");
        chk("R1 irq", {7'b0, irq}, 8'h00);
        // R2 stopped
        idle(8, "R2 idle");
        rdx(8'h1A, 8'hFF, "R2 hi");
        rdx(8'h1B, 8'hFC, "R2 lo");
        // R11 count writes ignored
        wrt(8'h18, 8'h55, "R11 wr hi");
        wrt(8'h19, 8'h66, "R11 wr lo");
        rdx(8'h18, 8'hFF, "R11 hi");
        rdx(8'h19, 8'hFC, "R11 lo");
        // R10 compare storage
        wrt(8'h16, 8'hA5, "R10 wr");
        wrt(8'h17, 8'h3C, "R10 wr");
        rdx(8'h16, 8'hA5, "R10 hi");
        rdx(8'h17, 8'h3C, "R10 lo");
        // R3 first increment four edges after enable, interrupt disabled
        wrt(8'h12, 8'h01, "R3 enable");
        idle(2, "R3 wait");
        rdx(8'h19, 8'hFC, "R3 before fourth edge");
        idle(1, "R3 wait");
        rdx(8'h19, 8'hFD, "R3 after fourth edge");
        // R4 wrap with enable off: flag set, no request
        idle(14, "R4 run");
        rdx(8'h18, 8'h00, "R4 wrapped hi");
        rdm(8'h19, "R4 wrapped lo");
        chk("R5 masked irq", {7'b0, irq}, 8'h00);
        rdx(8'h1A, 8'h00, "R9 alt hi");
        rdm(8'h1B, "R9 alt lo");
        // R5 enable the interrupt
        wrt(8'h12, 8'h03, "R5 ie on");
        idle(1, "R5 wait");
        chk("R5 irq high", {7'b0, irq}, 8'h01);
        // R8 unarmed primary read keeps flag
        rdm(8'h18, "R8 unarmed hi");
        rdm(8'h19, "R8 unarmed lo");
        rdx(8'h13, 8'h80, "R8 flag kept");
        // R9 armed, alternate reads keep flag
        rdm(8'h1A, "R9 armed alt hi");
        rdm(8'h1B, "R9 armed alt lo");
        rdx(8'h13, 8'h80, "R9 flag kept");
        // R8 armed primary read clears
        rdm(8'h18, "R8 clear hi");
        rdm(8'h19, "R8 clear lo");
        rdx(8'h13, 8'h00, "R8 cleared");
        idle(2, "R8 irq drop");
        chk("R5 irq low", {7'b0, irq}, 8'h00);
        // R6 coherent capture through repeated high reads
        rdm(8'h18, "R6 hi 1");
        idle(9, "R6 wait");
        rdm(8'h18, "R6 hi 2");
        idle(7, "R6 wait");
        rdm(8'h19, "R6 lo");
        // R7 live low read
        idle(5, "R7 wait");
        rdm(8'h19, "R7 live lo");
        rdm(8'h1B, "R7 live lo alt");
        // R6 on alternate window
        rdm(8'h1A, "R6 alt hi");
        idle(6, "R6 wait");
        rdm(8'h1A, "R6 alt hi 2");
        idle(3, "R6 wait");
        rdm(8'h1B, "R6 alt lo");
        // R2 stop mid-run
        wrt(8'h12, 8'h02, "R2 stop");
        rdm(8'h18, "R2 hi");
        rdm(8'h19, "R2 lo");
        idle(10, "R2 hold");
        rdm(8'h18, "R2 hi later");
        rdm(8'h19, "R2 lo later");
        // R10 compare survives reset; R1 reload
        do_reset();
        rdx(8'h16, 8'hA5, "R10 hi after reset");
        rdx(8'h17, 8'h3C, "R10 lo after reset");
        rdx(8'h18, 8'hFF, "R1 hi after reset");
        rdx(8'h19, 8'hFC, "R1 lo after reset");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule